// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block gathers interrupt events from four serial channels and a few device-wide sources. For each channel it keeps a pending flag per source and shows the most urgent pending source as a 3-bit code. The four codes are packed into one status word. The channel-side events are receive data available, receive line errors, receive idle timeout, transmit space available, modem-line change, flow-control character seen and match character seen. The device-wide events are a general-purpose pin change, a timer expiry and a wake from sleep.

Each flag stays set until the register read that belongs to it. An event that arrives in the same cycle as its clearing read wins, so no event is lost. Device-wide sources show only in channel 0's field, and only once channel 0 has no serial source pending. The wake indicator has no code of its own. It is seen through channel 0's pending summary bit.

Software, or a bus-side wrapper, reads the packed word to find which channel needs service and why. It uses the single registered request line as the interrupt to the host.

Top module: `uart_irq_prio`

## Requirements
- R1: While `rst` is high at a clock edge, every pending flag clears. After that edge `code_word` is zero, `chan_pend` is zero and `irq` is low.
- R2: Channel n's code sits at `code_word[3n+10:3n+8]`, and bits [7:0] are always zero. The code values are:
  - 3'b001: receive data available, or any of the channel's four line-error bits.
  - 3'b010: receive idle timeout.
  - 3'b011: transmit space available.
  - 3'b100: modem-line change, flow-control character or match character.
  - 3'b000: nothing pending.
  
  An event sampled at a clock edge shows in the field right after that edge.
- R3: When several sources of a channel are pending, the field shows the numerically lowest nonzero code among them.
- R4: The timer and pin-change sources use these codes:
  - 3'b110: pin change.
  - 3'b111: timer.
  
  Pin change is shown before timer. These codes appear only in channel 0's field, and only while channel 0 has no serial source pending. Channels 1 to 3 never show a code above 3'b100, and 3'b101 is never produced.
- R5: `wake_ev` sets a wake flag. The wake flag leaves channel 0's code unchanged but sets `chan_pend[0]`. `top_stat_rd` clears it.
- R6: `fifo_rd[n]` clears channel n's receive-data and idle-timeout flags. `line_stat_rd[n]` clears its line-error flag.
- R7: `id_rd[n]` clears channel n's transmit-space, flow-character and match-character flags. `modem_stat_rd[n]` clears its modem-change flag.
- R8: `tmr_ctl_rd` clears the timer flag and `gpio_lvl_rd` clears the pin-change flag. A read for one channel leaves the other channels' flags untouched.
- R9: An event in the same cycle as the read that would clear it leaves the flag set.
- R10: `chan_pend[n]` is high when channel n's field is nonzero (channel 0 also when the wake flag is set). `irq` is the registered OR of `chan_pend`, one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_avail_ev | input | NUM_CH | Receive data available, per channel |
| rx_err_ev | input | NUM_CH*LS_W | Line error bits, LS_W per channel |
| rx_idle_ev | input | NUM_CH | Receive idle timeout, per channel |
| tx_space_ev | input | NUM_CH | Transmit space available, per channel |
| modem_chg_ev | input | NUM_CH | Modem or handshake line change, per channel |
| flow_chg_ev | input | NUM_CH | Flow-control character seen, per channel |
| char_match_ev | input | NUM_CH | Match character seen, per channel |
| fifo_rd | input | NUM_CH | Receive FIFO read strobe |
| line_stat_rd | input | NUM_CH | Line status read strobe |
| id_rd | input | NUM_CH | Interrupt identification read strobe |
| modem_stat_rd | input | NUM_CH | Modem status read strobe |
| gpio_chg_ev | input | 1 | Device pin change event |
| tmr_exp_ev | input | 1 | Device timer expiry event |
| wake_ev | input | 1 | Wake from sleep event |
| top_stat_rd | input | 1 | Top-level status read strobe (clears wake) |
| tmr_ctl_rd | input | 1 | Timer control read strobe |
| gpio_lvl_rd | input | 1 | Pin level read strobe |
| code_word | output | 8+3*NUM_CH | Packed per-channel source codes |
| chan_pend | output | NUM_CH | Per-channel pending summary |
| irq | output | 1 | Registered global interrupt request |

## Verification
A flag that is stuck, lost or cleared by the wrong read shows up in the owning channel's field on the cycle after the event or the read. A hidden lower-priority flag shows up once the sources above it are cleared. A wrong priority order or a device source leaking past channel 0's serial sources shows as a wrong code in the same cycle. A wrong summary shows one cycle later on `irq`. The bench sweeps every combination of channel and device events on each channel, follows each combination with a single clearing read, and compares the whole packed word after every step. This way, a wrong flag becomes visible within the next two cycles.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    parameter int CODE_W    = 3;
    parameter int FIELD_LSB = 8;

    typedef enum logic [CODE_W-1:0] {
        SRC_NONE  = 3'd0,
        SRC_RX    = 3'd1,
        SRC_IDLE  = 3'd2,
        SRC_TX    = 3'd3,
        SRC_MODEM = 3'd4,
        SRC_RSVD  = 3'd5,
        SRC_GPIO  = 3'd6,
        SRC_TMR   = 3'd7
    } src_code_e;

    typedef struct packed {
        logic rxd;   // receive data available
        logic lsr;   // line error
        logic tmo;   // receive idle timeout
        logic txr;   // transmit space
        logic msr;   // modem line change
        logic xsp;   // flow or match character
    } chan_flags_t;

    typedef struct packed {
        logic gpio;
        logic tmr;
        logic wake;
    } dev_flags_t;

    typedef struct packed {
        logic irq;
    } top_state_t;

endpackage

// File: rtl/uart_irq_chan.sv
module uart_irq_chan
    import uart_irq_pkg::*;
#(
    parameter int LS_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_avail_ev,
    input  logic [LS_W-1:0]   rx_err_ev,
    input  logic              rx_idle_ev,
    input  logic              tx_space_ev,
    input  logic              modem_chg_ev,
    input  logic              flow_chg_ev,
    input  logic              char_match_ev,
    input  logic              fifo_rd,
    input  logic              line_stat_rd,
    input  logic              id_rd,
    input  logic              modem_stat_rd,
    output logic [CODE_W-1:0] code
);

    chan_flags_t flags_d, flags_q;

    // Set wins over clear: an event in the read cycle stays pending.
    always_comb begin
        flags_d.rxd = rx_avail_ev                   | (flags_q.rxd & ~fifo_rd);
        flags_d.lsr = (|rx_err_ev)                  | (flags_q.lsr & ~line_stat_rd);
        flags_d.tmo = rx_idle_ev                    | (flags_q.tmo & ~fifo_rd);
        flags_d.txr = tx_space_ev                   | (flags_q.txr & ~id_rd);
        flags_d.msr = modem_chg_ev                  | (flags_q.msr & ~modem_stat_rd);
        flags_d.xsp = (flow_chg_ev | char_match_ev) | (flags_q.xsp & ~id_rd);
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    src_code_e code_e;

    always_comb begin
        if (flags_q.rxd || flags_q.lsr)      code_e = SRC_RX;
        else if (flags_q.tmo)                code_e = SRC_IDLE;
        else if (flags_q.txr)                code_e = SRC_TX;
        else if (flags_q.msr || flags_q.xsp) code_e = SRC_MODEM;
        else                                 code_e = SRC_NONE;
    end

    assign code = code_e;

endmodule

// File: rtl/uart_irq_dev.sv
module uart_irq_dev
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              gpio_chg_ev,
    input  logic              tmr_exp_ev,
    input  logic              wake_ev,
    input  logic              top_stat_rd,
    input  logic              tmr_ctl_rd,
    input  logic              gpio_lvl_rd,
    output logic [CODE_W-1:0] dev_code,
    output logic              wake_pend
);

    dev_flags_t dflags_d, dflags_q;

    always_comb begin
        dflags_d.gpio = gpio_chg_ev | (dflags_q.gpio & ~gpio_lvl_rd);
        dflags_d.tmr  = tmr_exp_ev  | (dflags_q.tmr  & ~tmr_ctl_rd);
        dflags_d.wake = wake_ev     | (dflags_q.wake & ~top_stat_rd);
    end

    always_ff @(posedge clk) begin
        if (rst) dflags_q <= '0;
        else     dflags_q <= dflags_d;
    end

    src_code_e dev_e;

    always_comb begin
        if (dflags_q.gpio)     dev_e = SRC_GPIO;
        else if (dflags_q.tmr) dev_e = SRC_TMR;
        else                   dev_e = SRC_NONE;
    end

    assign dev_code  = dev_e;
    assign wake_pend = dflags_q.wake;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int LS_W   = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [NUM_CH-1:0]                    rx_avail_ev,
    input  logic [NUM_CH*LS_W-1:0]               rx_err_ev,
    input  logic [NUM_CH-1:0]                    rx_idle_ev,
    input  logic [NUM_CH-1:0]                    tx_space_ev,
    input  logic [NUM_CH-1:0]                    modem_chg_ev,
    input  logic [NUM_CH-1:0]                    flow_chg_ev,
    input  logic [NUM_CH-1:0]                    char_match_ev,
    input  logic [NUM_CH-1:0]                    fifo_rd,
    input  logic [NUM_CH-1:0]                    line_stat_rd,
    input  logic [NUM_CH-1:0]                    id_rd,
    input  logic [NUM_CH-1:0]                    modem_stat_rd,
    input  logic                                 gpio_chg_ev,
    input  logic                                 tmr_exp_ev,
    input  logic                                 wake_ev,
    input  logic                                 top_stat_rd,
    input  logic                                 tmr_ctl_rd,
    input  logic                                 gpio_lvl_rd,
    output logic [FIELD_LSB+NUM_CH*CODE_W-1:0]   code_word,
    output logic [NUM_CH-1:0]                    chan_pend,
    output logic                                 irq
);

    localparam int WORD_W = FIELD_LSB + NUM_CH * CODE_W;

    logic [NUM_CH-1:0][CODE_W-1:0] uart_code;
    logic [NUM_CH-1:0][CODE_W-1:0] field;
    logic [CODE_W-1:0]             dev_code;
    logic                          wake_pend;

    uart_irq_dev u_dev (
        .clk         (clk),
        .rst         (rst),
        .gpio_chg_ev (gpio_chg_ev),
        .tmr_exp_ev  (tmr_exp_ev),
        .wake_ev     (wake_ev),
        .top_stat_rd (top_stat_rd),
        .tmr_ctl_rd  (tmr_ctl_rd),
        .gpio_lvl_rd (gpio_lvl_rd),
        .dev_code    (dev_code),
        .wake_pend   (wake_pend)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        uart_irq_chan #(.LS_W(LS_W)) u_chan (
            .clk           (clk),
            .rst           (rst),
            .rx_avail_ev   (rx_avail_ev[n]),
            .rx_err_ev     (rx_err_ev[n*LS_W +: LS_W]),
            .rx_idle_ev    (rx_idle_ev[n]),
            .tx_space_ev   (tx_space_ev[n]),
            .modem_chg_ev  (modem_chg_ev[n]),
            .flow_chg_ev   (flow_chg_ev[n]),
            .char_match_ev (char_match_ev[n]),
            .fifo_rd       (fifo_rd[n]),
            .line_stat_rd  (line_stat_rd[n]),
            .id_rd         (id_rd[n]),
            .modem_stat_rd (modem_stat_rd[n]),
            .code          (uart_code[n])
        );

        if (n == 0) begin : g_dev_merge
            // Device-wide sources rank below every serial source of channel 0.
            assign field[n]     = (uart_code[n] != '0) ? uart_code[n] : dev_code;
            assign chan_pend[n] = (field[n] != '0) | wake_pend;
        end else begin : g_plain
            assign field[n]     = uart_code[n];
            assign chan_pend[n] = (field[n] != '0);
        end
    end

    assign code_word = {field, {FIELD_LSB{1'b0}}};

    top_state_t st_d, st_q;

    always_comb begin
        st_d.irq = |chan_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign irq = st_q.irq;

endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk
    import uart_irq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_CH-1:0]          rx_avail_ev,
    input logic                       tx0_ev,
    input logic [NUM_CH*CODE_W-1:0]   fields,
    input logic [NUM_CH-1:0]          chan_pend,
    input logic                       irq
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (fields == '0 && chan_pend == '0 && irq == 1'b0));

    assert_dev_deferred_R4: assert property (@(posedge clk) disable iff (rst)
        tx0_ev |=> (fields[CODE_W-1:0] != 3'd0 && fields[CODE_W-1:0] <= 3'd3));

    assert_irq_set_R10: assert property (@(posedge clk) disable iff (rst)
        (|chan_pend) |=> irq);

    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (rst)
        !(|chan_pend) |=> !irq);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        // R3 / R9: receive data outranks all and survives a same-cycle read
        assert_rx_top_prio_R3: assert property (@(posedge clk) disable iff (rst)
            rx_avail_ev[n] |=> (fields[n*CODE_W +: CODE_W] == 3'd1));

        if (n > 0) begin : g_other
            assert_dev_only_ch0_R4: assert property (@(posedge clk) disable iff (rst)
                fields[n*CODE_W +: CODE_W] <= 3'd4);
        end else begin : g_zero
            assert_no_reserved_R4: assert property (@(posedge clk) disable iff (rst)
                fields[CODE_W-1:0] != 3'd5);
        end
    end

endmodule

bind uart_irq_prio uart_irq_prio_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_avail_ev (rx_avail_ev),
    .tx0_ev      (tx_space_ev[0]),
    .fields      (code_word[WORD_W-1:FIELD_LSB]),
    .chan_pend   (chan_pend),
    .irq         (irq)
);

// File: tb/uart_irq_prio_bench.sv
module uart_irq_prio_bench;
    import uart_irq_pkg::*;

    localparam int NCH = 4;
    localparam int LSW = 4;
    localparam int WW  = FIELD_LSB + NCH * CODE_W;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                rst;
    logic [NCH-1:0]      rx_avail_ev, rx_idle_ev, tx_space_ev, modem_chg_ev;
    logic [NCH-1:0]      flow_chg_ev, char_match_ev;
    logic [NCH-1:0]      fifo_rd, line_stat_rd, id_rd, modem_stat_rd;
    logic [NCH*LSW-1:0]  rx_err_ev;
    logic                gpio_chg_ev, tmr_exp_ev, wake_ev;
    logic                top_stat_rd, tmr_ctl_rd, gpio_lvl_rd;
    logic [WW-1:0]       code_word;
    logic [NCH-1:0]      chan_pend;
    logic                irq;

    uart_irq_prio #(.NUM_CH(NCH), .LS_W(LSW)) u_uart_irq_prio (
        .clk(clk), .rst(rst),
        .rx_avail_ev(rx_avail_ev), .rx_err_ev(rx_err_ev), .rx_idle_ev(rx_idle_ev),
        .tx_space_ev(tx_space_ev), .modem_chg_ev(modem_chg_ev),
        .flow_chg_ev(flow_chg_ev), .char_match_ev(char_match_ev),
        .fifo_rd(fifo_rd), .line_stat_rd(line_stat_rd), .id_rd(id_rd),
        .modem_stat_rd(modem_stat_rd),
        .gpio_chg_ev(gpio_chg_ev), .tmr_exp_ev(tmr_exp_ev), .wake_ev(wake_ev),
        .top_stat_rd(top_stat_rd), .tmr_ctl_rd(tmr_ctl_rd), .gpio_lvl_rd(gpio_lvl_rd),
        .code_word(code_word), .chan_pend(chan_pend), .irq(irq)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Reference state: bit0 rx data, 1 line err, 2 idle, 3 tx, 4 modem, 5 flow/match
    logic [5:0] m_f [NCH];
    logic       m_gpio, m_tmr, m_wake, m_irq;

    function automatic logic [2:0] exp_uart(int n);
        if (m_f[n][0] || m_f[n][1]) return 3'd1;
        if (m_f[n][2])              return 3'd2;
        if (m_f[n][3])              return 3'd3;
        if (m_f[n][4] || m_f[n][5]) return 3'd4;
        return 3'd0;
    endfunction

    function automatic logic [2:0] exp_field(int n);
        if (n == 0 && exp_uart(0) == 3'd0)
            return m_gpio ? 3'd6 : (m_tmr ? 3'd7 : 3'd0);
        return exp_uart(n);
    endfunction

    function automatic logic [WW-1:0] exp_word();
        logic [WW-1:0] w = '0;
        for (int n = 0; n < NCH; n++) w[FIELD_LSB + 3*n +: 3] = exp_field(n);
        return w;
    endfunction

    function automatic logic [NCH-1:0] exp_pend();
        logic [NCH-1:0] p;
        for (int n = 0; n < NCH; n++) p[n] = (exp_field(n) != 3'd0);
        p[0] = p[0] | m_wake;
        return p;
    endfunction

    task automatic idle_inputs();
        rx_avail_ev = '0; rx_idle_ev = '0; tx_space_ev = '0; modem_chg_ev = '0;
        flow_chg_ev = '0; char_match_ev = '0; rx_err_ev = '0;
        fifo_rd = '0; line_stat_rd = '0; id_rd = '0; modem_stat_rd = '0;
        gpio_chg_ev = 1'b0; tmr_exp_ev = 1'b0; wake_ev = 1'b0;
        top_stat_rd = 1'b0; tmr_ctl_rd = 1'b0; gpio_lvl_rd = 1'b0;
    endtask

    // One clock edge; the model follows the requirement rules, inputs then idle.
    task automatic tick();
        @(posedge clk);
        if (rst) begin
            for (int n = 0; n < NCH; n++) m_f[n] = '0;
            m_gpio = 1'b0; m_tmr = 1'b0; m_wake = 1'b0; m_irq = 1'b0;
        end else begin
            m_irq = |exp_pend();
            for (int n = 0; n < NCH; n++) begin
                m_f[n][0] = rx_avail_ev[n]  | (m_f[n][0] & ~fifo_rd[n]);
                m_f[n][1] = (|rx_err_ev[n*LSW +: LSW]) | (m_f[n][1] & ~line_stat_rd[n]);
                m_f[n][2] = rx_idle_ev[n]   | (m_f[n][2] & ~fifo_rd[n]);
                m_f[n][3] = tx_space_ev[n]  | (m_f[n][3] & ~id_rd[n]);
                m_f[n][4] = modem_chg_ev[n] | (m_f[n][4] & ~modem_stat_rd[n]);
                m_f[n][5] = flow_chg_ev[n] | char_match_ev[n] | (m_f[n][5] & ~id_rd[n]);
            end
            m_gpio = gpio_chg_ev | (m_gpio & ~gpio_lvl_rd);
            m_tmr  = tmr_exp_ev  | (m_tmr  & ~tmr_ctl_rd);
            m_wake = wake_ev     | (m_wake & ~top_stat_rd);
        end
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic check_all(string tag);
        n_chk++;
        if (code_word !== exp_word()) begin
            n_fail++;
            $display("FAIL %s code_word act %h exp %h", tag, code_word, exp_word());
        end
        n_chk++;
        if (chan_pend !== exp_pend()) begin
            n_fail++;
            $display("FAIL %s chan_pend act %b exp %b", tag, chan_pend, exp_pend());
        end
        n_chk++;
        if (irq !== m_irq) begin
            n_fail++;
            $display("FAIL %s irq act %b exp %b", tag, irq, m_irq);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act timeout exp finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        do_reset();
        check_all("R1");

        // Sweep: every event combination on each channel, then one clearing read.
        for (int ch = 0; ch < NCH; ch++) begin
            for (int m = 0; m < 512; m++) begin
                logic [8:0] mv;
                int r;
                mv = 9'(m);
                do_reset();
                rx_avail_ev[ch]   = mv[0];
                rx_err_ev[ch*LSW + (m % LSW)] = mv[1];
                rx_idle_ev[ch]    = mv[2];
                tx_space_ev[ch]   = mv[3];
                modem_chg_ev[ch]  = mv[4];
                flow_chg_ev[ch]   = mv[5];
                char_match_ev[ch] = mv[6];
                gpio_chg_ev       = mv[7];
                tmr_exp_ev        = mv[8];
                tick();
                check_all("R2 R3 R4");
                tick();
                check_all("R10");
                r = m % 7;
                case (r)
                    0: fifo_rd[ch]       = 1'b1;
                    1: line_stat_rd[ch]  = 1'b1;
                    2: id_rd[ch]         = 1'b1;
                    3: modem_stat_rd[ch] = 1'b1;
                    4: tmr_ctl_rd        = 1'b1;
                    5: gpio_lvl_rd       = 1'b1;
                    default: top_stat_rd = 1'b1;
                endcase
                tick();
                if (r < 2)       check_all("R6");
                else if (r < 4)  check_all("R7");
                else             check_all("R8");
            end
        end

        // R9: events in the same cycle as their clearing reads stay pending
        do_reset();
        rx_avail_ev[2] = 1'b1; tx_space_ev[1] = 1'b1; gpio_chg_ev = 1'b1;
        tick();
        rx_avail_ev[2] = 1'b1; fifo_rd[2] = 1'b1;
        tx_space_ev[1] = 1'b1; id_rd[1] = 1'b1;
        gpio_chg_ev = 1'b1; gpio_lvl_rd = 1'b1;
        tick();
        check_all("R9");
        modem_chg_ev[3] = 1'b1; modem_stat_rd[3] = 1'b1;
        rx_err_ev[3*LSW] = 1'b1; line_stat_rd[3] = 1'b1;
        tmr_exp_ev = 1'b1; tmr_ctl_rd = 1'b1;
        tick();
        check_all("R9");

        // R8: a read for one channel leaves the other channels alone
        do_reset();
        rx_avail_ev = '1; tx_space_ev[3] = 1'b1;
        tick();
        fifo_rd[1] = 1'b1; id_rd[2] = 1'b1;
        tick();
        check_all("R8");
        fifo_rd[3] = 1'b1;
        tick();
        check_all("R8");

        // R5: wake flag shows only through the channel 0 summary
        do_reset();
        wake_ev = 1'b1;
        tick();
        check_all("R5");
        tick();
        check_all("R5");
        tx_space_ev[0] = 1'b1;
        tick();
        check_all("R5");
        top_stat_rd = 1'b1;
        tick();
        check_all("R5");
        id_rd[0] = 1'b1;
        tick();
        check_all("R5");
        tick();
        check_all("R10");

        // R4: device codes wait for channel 0 serial sources to clear
        do_reset();
        gpio_chg_ev = 1'b1; tmr_exp_ev = 1'b1; rx_idle_ev[0] = 1'b1;
        modem_chg_ev[1] = 1'b1;
        tick();
        check_all("R4");
        fifo_rd[0] = 1'b1;
        tick();
        check_all("R4");
        gpio_lvl_rd = 1'b1;
        tick();
        check_all("R4");
        tmr_ctl_rd = 1'b1;
        tick();
        check_all("R4");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule